// File: doc/BRIEF.md
# Software-Managed TLB with Assist-Register Search and Write

This block holds a small, fully associative translation buffer that system software maintains itself. Software never touches the entries directly. It loads a bank of assist registers through a simple register port, then issues one of two commands. A write command copies the assist-register fields into one entry. A search command looks up a 32-bit effective address and loads the assist registers with either the matching entry or a default miss image. Software then reads that image back.

A command strobe carries an opcode, a flag that says the instruction's A-register field is nonzero, and the address operand. Every command finishes in the clock edge that samples the strobe. A one-cycle done pulse follows. A search issued with a nonzero A field is an illegal form. It raises an illegal-instruction pulse instead of performing a lookup.

Top module: `tlb_assist_unit`

## Requirements
- R1: After reset all entries are invalid, every assist register reads zero, and `op_done` and `illegal_instr` are low.
- R2: The software port writes and reads these assist registers. Index 0 holds array-select at bit 28 and entry-select at bits 3:0. Index 1 holds valid at bit 31, address-space at bit 16 and entry ID at bits 15:0. Index 2 holds page number at bits 31:12. Index 3 holds the low real page at bits 31:12 and permissions at bits 5:0. Index 6 holds search address-space at bit 16 and search PID at bits 7:0. Index 7 holds the upper real page at bits 3:0. All other bits, and indices 4 and 5, read as zero.
- R3: A search (`cmd_op`=0) with `cmd_ra_nz`=1 pulses `illegal_instr` together with `op_done` and leaves every assist register unchanged.
- R4: `op_done` is high for exactly the one cycle after each accepted strobe.
- R5: An entry matches when it is valid, its address-space bit equals the search address-space bit, its page number equals `cmd_rb[31:12]`, and its ID is zero or equals the search PID followed by eight zero bits.
- R6: On a hit, index 0 gets array-select 0 and the entry number. Index 1 gets valid=1 and the entry's address-space bit and ID. Indices 2, 3 and 7 get the entry's page, real page and permissions.
- R7: On a miss, index 0 is unchanged and index 1 gets valid=0, the search address-space bit, and the ID {PID, 8'h00}. Index 2 gets `cmd_rb[31:12]`, and indices 3 and 7 read zero.
- R8: A write (`cmd_op`=1) updates the entry numbered by entry-select when array-select is 0. With array-select 1, no entry changes.
- R9: A write stores valid, address-space bit, ID, page, the 24-bit real page (upper 4 bits from index 7) and the permissions, and it leaves the assist registers unchanged.
- R10: When several entries match, the lowest-numbered one is reported.
- R11: A software register write in the same cycle as a command strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = search, 1 = write |
| cmd_ra_nz | input | 1 | Instruction A field is nonzero |
| cmd_rb | input | 32 | Search effective address operand |
| sw_we | input | 1 | Assist-register write enable |
| sw_addr | input | 3 | Assist-register index |
| sw_wdata | input | 32 | Assist-register write data |
| sw_rdata | output | 32 | Assist-register read data (combinational) |
| op_done | output | 1 | Command completion pulse |
| illegal_instr | output | 1 | Illegal-form search pulse |

## Verification
The hardest situation to reach from the ports is a search where several entries match at once, some through a global zero ID and some through an exact ID. Here the priority order and the ID rule interact. Random stimulus draws page numbers, IDs and PIDs from very small pools, so that duplicates and global entries appear often. A directed case also plants two identical entries, at positions 2 and 9. Concurrent software writes and illegal-form searches are mixed into the same random stream.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned TLB_ENTRIES = 16;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned TID_W       = 16;
    localparam int unsigned PID_W       = 8;
    localparam int unsigned EPN_W       = 20;
    localparam int unsigned RPN_LO_W    = 20;
    localparam int unsigned RPN_HI_W    = 4;
    localparam int unsigned RPN_W       = RPN_LO_W + RPN_HI_W;
    localparam int unsigned PERM_W      = 6;
    localparam int unsigned REG_IDX_W   = 3;

    localparam int unsigned ARR_BIT     = 28;
    localparam int unsigned VALID_BIT   = 31;
    localparam int unsigned SPACE_BIT   = 16;
    localparam int unsigned PAGE_LSB    = DATA_W - EPN_W;

    localparam logic [REG_IDX_W-1:0] REG_SEL  = 3'd0;
    localparam logic [REG_IDX_W-1:0] REG_TAG  = 3'd1;
    localparam logic [REG_IDX_W-1:0] REG_PAGE = 3'd2;
    localparam logic [REG_IDX_W-1:0] REG_REAL = 3'd3;
    localparam logic [REG_IDX_W-1:0] REG_SRCH = 3'd6;
    localparam logic [REG_IDX_W-1:0] REG_UPPR = 3'd7;

    typedef enum logic {
        OP_SEARCH = 1'b0,
        OP_WRITE  = 1'b1
    } tlb_op_e;

    typedef struct packed {
        logic                valid;
        logic                ts;
        logic [TID_W-1:0]    tid;
        logic [EPN_W-1:0]    epn;
        logic [RPN_W-1:0]    rpn;
        logic [PERM_W-1:0]   perm;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  tlb_entry_t               wr_data,
    output tlb_entry_t [ENTRIES-1:0] ents_o
);
    tlb_entry_t [ENTRIES-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (wr_en) begin
            ents_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents_o = ents_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_hold
        // R8
        entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(ents_q[g]));
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0] ents_i,
    input  logic                     srch_as_i,
    input  logic [TID_W-1:0]         srch_tid_i,
    input  logic [EPN_W-1:0]         srch_epn_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o,
    output tlb_entry_t               hit_ent_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ents_i[g].valid
                       && (ents_i[g].ts == srch_as_i)
                       && (ents_i[g].epn == srch_epn_i)
                       && ((ents_i[g].tid == srch_tid_i) || (ents_i[g].tid == '0));
    end

    always_comb begin
        hit_o     = |match;
        hit_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx_o = IDX_W'(i);
            end
        end
        hit_ent_o = ents_i[hit_idx_o];
    end

    always_comb begin
        if (hit_o) begin
            // R10
            lowest_hit_chk: assert (match[hit_idx_o]
                && ((match & ((ENTRIES'(1) << hit_idx_o) - ENTRIES'(1))) == '0));
        end
    end
endmodule

// File: rtl/tlb_assist_unit.sv
module tlb_assist_unit
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_op,
    input  logic                  cmd_ra_nz,
    input  logic [DATA_W-1:0]     cmd_rb,
    input  logic                  sw_we,
    input  logic [REG_IDX_W-1:0]  sw_addr,
    input  logic [DATA_W-1:0]     sw_wdata,
    output logic [DATA_W-1:0]     sw_rdata,
    output logic                  op_done,
    output logic                  illegal_instr
);
    typedef struct packed {
        logic                  arr_sel;
        logic [IDX_W-1:0]      ent_sel;
        logic                  valid;
        logic                  ts;
        logic [TID_W-1:0]      tid;
        logic [EPN_W-1:0]      epn;
        logic [RPN_LO_W-1:0]   rpn_lo;
        logic [PERM_W-1:0]     perm;
        logic                  srch_as;
        logic [PID_W-1:0]      srch_pid;
        logic [RPN_HI_W-1:0]   rpn_hi;
    } arch_t;

    typedef struct packed {
        arch_t arch;
        logic  done;
        logic  ill;
    } state_t;

    state_t state_d, state_q;

    tlb_entry_t [ENTRIES-1:0] ents;
    tlb_entry_t               wr_data;
    tlb_entry_t               hit_ent;
    logic                     wr_en;
    logic                     hit;
    logic [IDX_W-1:0]         hit_idx;
    logic [TID_W-1:0]         srch_tid;
    tlb_op_e                  op;

    assign op       = tlb_op_e'(cmd_op);
    assign srch_tid = {state_q.arch.srch_pid, {(TID_W-PID_W){1'b0}}};

    assign wr_data.valid = state_q.arch.valid;
    assign wr_data.ts    = state_q.arch.ts;
    assign wr_data.tid   = state_q.arch.tid;
    assign wr_data.epn   = state_q.arch.epn;
    assign wr_data.rpn   = {state_q.arch.rpn_hi, state_q.arch.rpn_lo};
    assign wr_data.perm  = state_q.arch.perm;

    tlb_entry_array #(.ENTRIES(ENTRIES)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (state_q.arch.ent_sel),
        .wr_data (wr_data),
        .ents_o  (ents)
    );

    tlb_match #(.ENTRIES(ENTRIES)) i_match (
        .ents_i     (ents),
        .srch_as_i  (state_q.arch.srch_as),
        .srch_tid_i (srch_tid),
        .srch_epn_i (cmd_rb[DATA_W-1:PAGE_LSB]),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .hit_ent_o  (hit_ent)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.ill  = 1'b0;
        wr_en        = 1'b0;
        if (cmd_valid) begin
            state_d.done = 1'b1;
            if (op == OP_SEARCH) begin
                if (cmd_ra_nz) begin
                    state_d.ill = 1'b1;
                end else if (hit) begin
                    state_d.arch.arr_sel = 1'b0;
                    state_d.arch.ent_sel = hit_idx;
                    state_d.arch.valid   = 1'b1;
                    state_d.arch.ts      = hit_ent.ts;
                    state_d.arch.tid     = hit_ent.tid;
                    state_d.arch.epn     = hit_ent.epn;
                    state_d.arch.rpn_lo  = hit_ent.rpn[RPN_LO_W-1:0];
                    state_d.arch.rpn_hi  = hit_ent.rpn[RPN_W-1:RPN_LO_W];
                    state_d.arch.perm    = hit_ent.perm;
                end else begin
                    state_d.arch.valid   = 1'b0;
                    state_d.arch.ts      = state_q.arch.srch_as;
                    state_d.arch.tid     = srch_tid;
                    state_d.arch.epn     = cmd_rb[DATA_W-1:PAGE_LSB];
                    state_d.arch.rpn_lo  = '0;
                    state_d.arch.rpn_hi  = '0;
                    state_d.arch.perm    = '0;
                end
            end else begin
                wr_en = !state_q.arch.arr_sel;
            end
        end else if (sw_we) begin
            case (sw_addr)
                REG_SEL: begin
                    state_d.arch.arr_sel = sw_wdata[ARR_BIT];
                    state_d.arch.ent_sel = sw_wdata[IDX_W-1:0];
                end
                REG_TAG: begin
                    state_d.arch.valid = sw_wdata[VALID_BIT];
                    state_d.arch.ts    = sw_wdata[SPACE_BIT];
                    state_d.arch.tid   = sw_wdata[TID_W-1:0];
                end
                REG_PAGE: begin
                    state_d.arch.epn = sw_wdata[DATA_W-1:PAGE_LSB];
                end
                REG_REAL: begin
                    state_d.arch.rpn_lo = sw_wdata[DATA_W-1:PAGE_LSB];
                    state_d.arch.perm   = sw_wdata[PERM_W-1:0];
                end
                REG_SRCH: begin
                    state_d.arch.srch_as  = sw_wdata[SPACE_BIT];
                    state_d.arch.srch_pid = sw_wdata[PID_W-1:0];
                end
                REG_UPPR: begin
                    state_d.arch.rpn_hi = sw_wdata[RPN_HI_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sw_rdata = '0;
        case (sw_addr)
            REG_SEL: begin
                sw_rdata[ARR_BIT]     = state_q.arch.arr_sel;
                sw_rdata[IDX_W-1:0]   = state_q.arch.ent_sel;
            end
            REG_TAG: begin
                sw_rdata[VALID_BIT]   = state_q.arch.valid;
                sw_rdata[SPACE_BIT]   = state_q.arch.ts;
                sw_rdata[TID_W-1:0]   = state_q.arch.tid;
            end
            REG_PAGE: sw_rdata[DATA_W-1:PAGE_LSB] = state_q.arch.epn;
            REG_REAL: begin
                sw_rdata[DATA_W-1:PAGE_LSB] = state_q.arch.rpn_lo;
                sw_rdata[PERM_W-1:0]        = state_q.arch.perm;
            end
            REG_SRCH: begin
                sw_rdata[SPACE_BIT]   = state_q.arch.srch_as;
                sw_rdata[PID_W-1:0]   = state_q.arch.srch_pid;
            end
            REG_UPPR: sw_rdata[RPN_HI_W-1:0] = state_q.arch.rpn_hi;
            default: ;
        endcase
    end

    assign op_done       = state_q.done;
    assign illegal_instr = state_q.ill;

    logic unused_ok;
    assign unused_ok = ^{cmd_rb[PAGE_LSB-1:0], sw_wdata, hit_ent.valid, hit_ent.epn};

    // R4
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> op_done);

    // R4
    done_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> $past(cmd_valid));

    // R3
    illegal_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> ($stable(state_q.arch) && op_done));

    // R9
    write_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_WRITE) |=> $stable(state_q.arch));

    // R6
    hit_loads_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SEARCH && !cmd_ra_nz && hit)
        |=> (state_q.arch.valid && state_q.arch.ent_sel == $past(hit_idx)));

    // R7
    miss_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SEARCH && !cmd_ra_nz && !hit)
        |=> (!state_q.arch.valid && $stable(state_q.arch.ent_sel)));
endmodule

// File: tb/test_tlb_assist_unit.sv
module test_tlb_assist_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic        cmd_ra_nz = 1'b0;
    logic [31:0] cmd_rb = '0;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        op_done;
    logic        illegal_instr;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          ended = 1'b0;

    logic [31:0] mreg [8];
    logic        m_v    [16];
    logic        m_ts   [16];
    logic [15:0] m_tid  [16];
    logic [19:0] m_epn  [16];
    logic [23:0] m_rpn  [16];
    logic [5:0]  m_perm [16];

    always #10 clk = ~clk;

    tlb_assist_unit i_tlb_assist_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ra_nz(cmd_ra_nz), .cmd_rb(cmd_rb), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .op_done(op_done),
        .illegal_instr(illegal_instr)
    );

    function automatic logic [31:0] reg_mask(input logic [2:0] a);
        case (a)
            3'd0: return 32'h1000_000F;
            3'd1: return 32'h8001_FFFF;
            3'd2: return 32'hFFFF_F000;
            3'd3: return 32'hFFFF_F03F;
            3'd6: return 32'h0001_00FF;
            3'd7: return 32'h0000_000F;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_search(input logic [31:0] rb);
        logic        as_b;
        logic [15:0] pid16;
        int          found;
        as_b  = mreg[6][16];
        pid16 = {mreg[6][7:0], 8'h00};
        found = -1;
        for (int i = 0; i < 16; i++) begin
            if (found < 0 && m_v[i] && m_ts[i] == as_b && m_epn[i] == rb[31:12]
                && (m_tid[i] == pid16 || m_tid[i] == 16'h0)) found = i;
        end
        if (found >= 0) begin
            mreg[0] = {28'h0, 4'(found)};
            mreg[1] = {1'b1, 14'h0, m_ts[found], m_tid[found]};
            mreg[2] = {m_epn[found], 12'h0};
            mreg[3] = {m_rpn[found][19:0], 6'h0, m_perm[found]};
            mreg[7] = {28'h0, m_rpn[found][23:20]};
        end else begin
            mreg[1] = {1'b0, 14'h0, as_b, pid16};
            mreg[2] = {rb[31:12], 12'h0};
            mreg[3] = 32'h0;
            mreg[7] = 32'h0;
        end
    endtask

    task automatic model_write();
        int k;
        if (mreg[0][28] == 1'b0) begin
            k = int'(mreg[0][3:0]);
            m_v[k]    = mreg[1][31];
            m_ts[k]   = mreg[1][16];
            m_tid[k]  = mreg[1][15:0];
            m_epn[k]  = mreg[2][31:12];
            m_rpn[k]  = {mreg[7][3:0], mreg[3][31:12]};
            m_perm[k] = mreg[3][5:0];
        end
    endtask

    task automatic check_regs(input string req);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            sw_addr = 3'(a);
            #1;
            if (a == 0) chk("R4 done low after pulse", {31'h0, op_done}, 32'h0);
            chk(req, sw_rdata, mreg[a] & reg_mask(3'(a)));
        end
    endtask

    task automatic sw_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
        mreg[a] = d & reg_mask(a);
    endtask

    task automatic do_op(input logic op, input logic ra, input logic [31:0] rb,
                         input logic swwe, input logic [2:0] sa, input logic [31:0] sd,
                         input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ra_nz = ra; cmd_rb = rb;
        sw_we = swwe; sw_addr = sa; sw_wdata = sd;
        @(negedge clk);
        cmd_valid = 1'b0; sw_we = 1'b0;
        chk("R4 done pulse", {31'h0, op_done}, 32'h1);
        chk("R3 illegal flag", {31'h0, illegal_instr}, {31'h0, (op == 1'b0) && ra});
        if (op == 1'b0) begin
            if (!ra) model_search(rb);
        end else begin
            model_write();
        end
        check_regs(req);
    endtask

    task automatic load_entry(input int idx, input logic v, input logic ts,
                              input logic [15:0] tid, input logic [19:0] epn,
                              input logic [23:0] rpn, input logic [5:0] perm);
        sw_write(3'd0, 32'(idx));
        sw_write(3'd1, {v, 14'h0, ts, tid});
        sw_write(3'd2, {epn, 12'h0});
        sw_write(3'd3, {rpn[19:0], 6'h0, perm});
        sw_write(3'd7, {28'h0, rpn[23:20]});
        do_op(1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 32'h0, "R9 write keeps regs");
    endtask

    function automatic logic [31:0] rand_data(input logic [2:0] a);
        logic [31:0] w;
        w = $urandom;
        case (a)
            3'd0: w[28] = ($urandom % 8 == 0);
            3'd1: begin
                w[31]   = ($urandom % 4 != 0);
                w[15:0] = ($urandom % 3 == 0) ? 16'h0 : {5'h0, 3'($urandom), 8'h00};
            end
            3'd2: w[31:12] = {18'h2B1C3, 2'($urandom)};
            3'd6: w[7:0] = {5'h0, 3'($urandom)};
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_ts[i] = 0; m_tid[i] = 0; m_epn[i] = 0; m_rpn[i] = 0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 done after reset", {31'h0, op_done}, 32'h0);
        chk("R1 illegal after reset", {31'h0, illegal_instr}, 32'h0);
        check_regs("R1 regs zero");
        do_op(1'b0, 1'b0, 32'h0000_0000, 1'b0, 3'd0, 32'h0, "R1 empty buffer misses");

        // R2: masks and unimplemented indices
        for (int a = 0; a < 8; a++) sw_write(3'(a), 32'hFFFF_FFFF);
        check_regs("R2 readback mask");
        for (int a = 0; a < 8; a++) sw_write(3'(a), 32'h0);

        // R5 R6: global entry hits any PID
        load_entry(3, 1'b1, 1'b0, 16'h0000, 20'hABCDE, 24'h9_12345, 6'h2A);
        sw_write(3'd6, 32'h0000_0005);
        do_op(1'b0, 1'b0, 32'hABCD_E123, 1'b0, 3'd0, 32'h0, "R6 global hit");
        // R5: address-space mismatch misses
        sw_write(3'd6, 32'h0001_0005);
        do_op(1'b0, 1'b0, 32'hABCD_E000, 1'b0, 3'd0, 32'h0, "R5 space mismatch miss R7");
        // R5: ID mismatch
        load_entry(5, 1'b1, 1'b1, 16'h0700, 20'h11111, 24'hF_00001, 6'h11);
        sw_write(3'd6, 32'h0001_0006);
        do_op(1'b0, 1'b0, 32'h1111_1000, 1'b0, 3'd0, 32'h0, "R5 id mismatch miss");
        sw_write(3'd6, 32'h0001_0007);
        do_op(1'b0, 1'b0, 32'h1111_1FFF, 1'b0, 3'd0, 32'h0, "R5 id match hit");

        // R3: illegal form
        do_op(1'b0, 1'b1, 32'h1111_1000, 1'b0, 3'd0, 32'h0, "R3 illegal keeps regs");

        // R8: array-select 1 ignored
        sw_write(3'd0, 32'h1000_0008);
        sw_write(3'd1, 32'h8000_0000);
        sw_write(3'd2, 32'h5555_5000);
        do_op(1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 32'h0, "R8 array select 1");
        sw_write(3'd6, 32'h0);
        do_op(1'b0, 1'b0, 32'h5555_5000, 1'b0, 3'd0, 32'h0, "R8 no entry written");

        // R10: duplicates at 2 and 9
        load_entry(9, 1'b1, 1'b0, 16'h0000, 20'h77777, 24'h1_AAAAA, 6'h01);
        load_entry(2, 1'b1, 1'b0, 16'h0000, 20'h77777, 24'h2_BBBBB, 6'h02);
        do_op(1'b0, 1'b0, 32'h7777_7000, 1'b0, 3'd0, 32'h0, "R10 lowest index wins");

        // R11: concurrent software write ignored
        do_op(1'b0, 1'b0, 32'h7777_7000, 1'b1, 3'd6, 32'h0001_00FF, "R11 sw write dropped");
        do_op(1'b1, 1'b0, 32'h0, 1'b1, 3'd2, 32'hFFFF_F000, "R11 sw write dropped on write");

        // Random mix
        for (int n = 0; n < 500; n++) begin
            int          pick;
            logic [2:0]  a;
            pick = int'($urandom % 10);
            a = 3'($urandom);
            if (pick < 4) begin
                sw_write(a, rand_data(a));
            end else if (pick < 6) begin
                do_op(1'b1, 1'b0, $urandom, ($urandom % 6 == 0), a, rand_data(a), "R9 random write");
            end else begin
                do_op(1'b0, ($urandom % 12 == 0), {18'h2B1C3, 2'($urandom), 12'($urandom)},
                      ($urandom % 6 == 0), a, rand_data(a), "R5 R6 R7 random search");
            end
        end

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule